// File: doc/BRIEF.md
# Integer Register File with Selectable Storage Style

This block holds the general-purpose integer registers of a 32-bit load/store core. It has one write port and two read ports. Both read ports are registered, so data appears on the clock edge after the address is presented. A single elaboration-time switch picks how the words are stored. The default is a reset-free memory array that synthesis can map onto FPGA block RAM. The alternative is a bank of individual flip-flops that an asynchronous active-low reset clears completely.

In the flip-flop style, register 0 has no storage: it reads as zero and ignores writes. In the memory-array style, register 0 is a real word. Its zero value has to be established by the core's control logic through a dedicated clear input. A second switch halves the register count from 32 to 16 for the reduced base ISA. In that variant the top address bit carries no meaning.

Top module: `int_regfile`

## Requirements
- R1: Reads are synchronous in both styles: `rdata_a_o`/`rdata_b_o` present, one clock edge after sampling, the contents of the register addressed by `raddr_a_i`/`raddr_b_i` at that edge. `FLOP_STYLE` = 0 (the default) selects the memory array and 1 selects the flip-flop bank.
- R2: With `we_i` = 1 and a nonzero write index, `wdata_i` is stored at that index at the clock edge. A later read returns it.
- R3: In the flip-flop style, `rst_ni` = 0 asynchronously clears every stored word and both read outputs to zero. After reset, all addresses read zero.
- R4: In the flip-flop style, index 0 always reads zero. Writes to index 0 are ignored, and `clear_x0_i` has no effect.
- R5: In the memory-array style, `clear_x0_i` = 1 writes zero into storage word 0. It takes the single write port, so an ordinary write presented in the same cycle is dropped.
- R6: In the memory-array style, a write to index 0 with `clear_x0_i` = 0 leaves word 0 unchanged.
- R7: A read and a write to the same register in the same cycle return the old contents (read-before-write) in both styles.
- R8: With `REDUCED_SET` = 1 there are 16 registers and address bit 4 is ignored, so addresses k and k+16 name the same register for reads and writes.
- R9: The two read ports are independent. Each returns its own register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (clears the flip-flop style only) |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Write register address |
| wdata_i | input | 32 | Write data |
| raddr_a_i | input | 5 | Read port A address |
| raddr_b_i | input | 5 | Read port B address |
| clear_x0_i | input | 1 | Force a zero write into word 0 (memory-array style) |
| rdata_a_o | output | 32 | Read port A data, one cycle after its address |
| rdata_b_o | output | 32 | Read port B data, one cycle after its address |

## Verification
Two pairs of functions can land in the same cycle.

- **Read and write to one register.** The bench writes a register while both ports read that same address. It expects the old word on the next edge and the new word one cycle later.
- **Clear and ordinary write.** The bench pulses `clear_x0_i` while presenting a nonzero write. It expects word 0 to read zero and the target register to keep its prior value in the memory-array style. The flip-flop instances, fed the same stimulus, must take the write.

A behavioural model tracks each of the three configurations and is compared on every clock.

// File: rtl/int_rf_pkg.sv
`timescale 1ns/1ps
package int_rf_pkg;
  localparam int unsigned RF_XLEN   = 32;
  localparam int unsigned RF_ADDR_W = 5;

  // number of architectural registers for a given address width
  function automatic int unsigned rf_entries(input int unsigned addr_w, input bit reduced);
    return reduced ? (32'd1 << (addr_w - 1)) : (32'd1 << addr_w);
  endfunction
endpackage

// File: rtl/rf_addr_map.sv
`timescale 1ns/1ps
module rf_addr_map #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  // upper address bits beyond the register count carry no meaning
  assign idx_o = addr_i[IDX_W-1:0];
endmodule

// File: rtl/rf_ram_bank.sv
`timescale 1ns/1ps
module rf_ram_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREG   = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_a_i,
  input  logic [IDX_W-1:0]  rd_idx_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem_q [NREG];

  // plain array, no reset, registered reads: block RAM friendly
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
    rdata_a_o <= mem_q[rd_idx_a_i];
    rdata_b_o <= mem_q[rd_idx_b_i];
  end

  // word 0 may only ever receive zero (R5, R6)
  assert_x0_only_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == '0) |-> wr_data_i == '0)
    else $error("word 0 written with nonzero data");
endmodule

// File: rtl/rf_flop_bank.sv
`timescale 1ns/1ps
module rf_flop_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREG   = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_a_i,
  input  logic [IDX_W-1:0]  rd_idx_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [NREG-1:0][DATA_W-1:0] view;

  for (genvar i = 0; i < NREG; i++) begin : g_word
    if (i == 0) begin : g_zero
      assign view[i] = '0;  // no storage for index 0
    end else begin : g_reg
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                   word_q <= '0;
        else if (wr_en_i && wr_idx_i == IDX_W'(i))     word_q <= wr_data_i;
      end
      assign view[i] = word_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_a_o <= '0;
      rdata_b_o <= '0;
    end else begin
      rdata_a_o <= view[rd_idx_a_i];
      rdata_b_o <= view[rd_idx_b_i];
    end
  end

  logic rst_low_q;
  always_ff @(posedge clk_i) rst_low_q <= !rst_ni;

  always @(posedge clk_i) begin
    if (rst_low_q && !rst_ni)
      assert_rst_clear_R3: assert (rdata_a_o == '0 && rdata_b_o == '0)
        else $error("read outputs not cleared during reset");
  end

  assert_x0_read_a_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_a_i == '0 |=> rdata_a_o == '0) else $error("port A index 0 nonzero");
  assert_x0_read_b_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_b_i == '0 |=> rdata_b_o == '0) else $error("port B index 0 nonzero");
  assert_no_x0_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> wr_idx_i != '0) else $error("write enable reached index 0");
endmodule

// File: rtl/int_regfile.sv
`timescale 1ns/1ps
module int_regfile
  import int_rf_pkg::*;
#(
  parameter bit          FLOP_STYLE  = 1'b0,
  parameter bit          REDUCED_SET = 1'b0,
  parameter int unsigned DATA_W      = RF_XLEN,
  parameter int unsigned ADDR_W      = RF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  input  logic [ADDR_W-1:0] raddr_b_i,
  input  logic              clear_x0_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int unsigned NREG  = rf_entries(ADDR_W, REDUCED_SET);
  localparam int unsigned IDX_W = $clog2(NREG);

  logic [IDX_W-1:0]  w_idx, a_idx, b_idx;
  logic              bank_we;
  logic [IDX_W-1:0]  bank_widx;
  logic [DATA_W-1:0] bank_wdata;

  rf_addr_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_map_w (.addr_i(waddr_i),   .idx_o(w_idx));
  rf_addr_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_map_a (.addr_i(raddr_a_i), .idx_o(a_idx));
  rf_addr_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_map_b (.addr_i(raddr_b_i), .idx_o(b_idx));

  if (FLOP_STYLE) begin : g_flop
    always_comb begin
      bank_we    = we_i && (w_idx != '0);
      bank_widx  = w_idx;
      bank_wdata = wdata_i;
    end

    rf_flop_bank #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) i_bank (
      .clk_i, .rst_ni,
      .wr_en_i(bank_we), .wr_idx_i(bank_widx), .wr_data_i(bank_wdata),
      .rd_idx_a_i(a_idx), .rd_idx_b_i(b_idx),
      .rdata_a_o, .rdata_b_o
    );
  end else begin : g_ram
    // clear request owns the write port
    always_comb begin
      if (clear_x0_i) begin
        bank_we    = 1'b1;
        bank_widx  = '0;
        bank_wdata = '0;
      end else begin
        bank_we    = we_i && (w_idx != '0);
        bank_widx  = w_idx;
        bank_wdata = wdata_i;
      end
    end

    rf_ram_bank #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) i_bank (
      .clk_i, .rst_ni,
      .wr_en_i(bank_we), .wr_idx_i(bank_widx), .wr_data_i(bank_wdata),
      .rd_idx_a_i(a_idx), .rd_idx_b_i(b_idx),
      .rdata_a_o, .rdata_b_o
    );

    assert_clear_x0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_x0_i ##1 (a_idx == '0) |=> rdata_a_o == '0)
      else $error("word 0 not zero after clear");
  end
endmodule

// File: tb/test_int_regfile.sv
`timescale 1ns/1ps
module test_int_regfile;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0, clr = 1'b0;
  logic [4:0]  waddr = '0, ra = '0, rb = '0;
  logic [31:0] wdata = '0;
  logic [31:0] fa, fb, ma, mb, ea, eb;

  int    nchk = 0, nerr = 0, cyc = 0;
  string cur_req = "R3";

  always #10 clk = ~clk;

  int_regfile #(.FLOP_STYLE(1'b1), .REDUCED_SET(1'b0)) i_int_regfile (
    .clk_i(clk), .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(ra), .raddr_b_i(rb), .clear_x0_i(clr), .rdata_a_o(fa), .rdata_b_o(fb));
  int_regfile #(.FLOP_STYLE(1'b0), .REDUCED_SET(1'b0)) i_int_regfile_ram (
    .clk_i(clk), .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(ra), .raddr_b_i(rb), .clear_x0_i(clr), .rdata_a_o(ma), .rdata_b_o(mb));
  int_regfile #(.FLOP_STYLE(1'b1), .REDUCED_SET(1'b1)) i_int_regfile_e (
    .clk_i(clk), .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(ra), .raddr_b_i(rb), .clear_x0_i(clr), .rdata_a_o(ea), .rdata_b_o(eb));

  // behavioural reference models
  logic [31:0] mf [32];
  logic [31:0] mm [32];
  bit          mv [32];
  logic [31:0] me [16];
  logic [31:0] xfa = '0, xfb = '0, xma = '0, xmb = '0, xea = '0, xeb = '0;
  bit          xva = 1'b0, xvb = 1'b0;

  initial begin
    for (int i = 0; i < 32; i++) begin mf[i] = '0; mm[i] = '0; mv[i] = 1'b0; end
    for (int i = 0; i < 16; i++) me[i] = '0;
  end

  always @(posedge clk) begin
    cyc++;
    if (!rst_ni) begin
      for (int i = 0; i < 32; i++) mf[i] = '0;
      for (int i = 0; i < 16; i++) me[i] = '0;
      xfa = '0; xfb = '0; xea = '0; xeb = '0;
    end else begin
      xfa = (ra == 0) ? '0 : mf[ra];
      xfb = (rb == 0) ? '0 : mf[rb];
      xea = (ra[3:0] == 0) ? '0 : me[ra[3:0]];
      xeb = (rb[3:0] == 0) ? '0 : me[rb[3:0]];
      if (we && waddr != 0)      mf[waddr] = wdata;
      if (we && waddr[3:0] != 0) me[waddr[3:0]] = wdata;
    end
    // memory-array style has no reset
    xma = mm[ra]; xva = mv[ra];
    xmb = mm[rb]; xvb = mv[rb];
    if (clr) begin mm[0] = '0; mv[0] = 1'b1; end
    else if (we && waddr != 0) begin mm[waddr] = wdata; mv[waddr] = 1'b1; end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 0) begin
      check("flop32.a", fa, rst_ni ? xfa : 32'h0);
      check("flop32.b", fb, rst_ni ? xfb : 32'h0);
      check("flop16.a", ea, rst_ni ? xea : 32'h0);
      check("flop16.b", eb, rst_ni ? xeb : 32'h0);
      if (xva) check("ram32.a", ma, xma);
      if (xvb) check("ram32.b", mb, xmb);
    end
  end

  task automatic step(input bit w, input logic [4:0] wa, input logic [31:0] wd,
                      input logic [4:0] a, input logic [4:0] b, input bit c);
    we = w; waddr = wa; wdata = wd; ra = a; rb = b; clr = c;
    @(posedge clk);
    #2;
  endtask

  task automatic read_all();
    for (int i = 0; i < 32; i++) step(1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i), 1'b0);
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, 1'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R3: reset clears flop banks; all addresses read zero afterwards
    cur_req = "R3";
    repeat (3) step(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, 1'b0);
    rst_ni = 1'b1;
    read_all();

    // R5: clear takes the port, concurrent write to 7 dropped in memory style
    cur_req = "R5";
    step(1'b1, 5'd7, 32'hdeadbeef, 5'd0, 5'd7, 1'b1);
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd7, 1'b0);
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd7, 1'b0);

    // R2 / R9: fill every register, read back with both ports on different words
    cur_req = "R2";
    for (int i = 1; i < 32; i++)
      step(1'b1, 5'(i), (32'(i) * 32'h01010101) ^ 32'h5a5a0000, 5'(i - 1), 5'(32 - i), 1'b0);
    cur_req = "R9";
    read_all();

    // R1: alternating addresses every cycle, one-cycle latency
    cur_req = "R1";
    for (int i = 0; i < 8; i++) step(1'b0, 5'd0, 32'h0, 5'(i * 3 + 1), 5'(30 - i * 2), 1'b0);

    // R4 / R6: write to index 0 is ignored in both styles
    cur_req = "R4";
    step(1'b1, 5'd0, 32'hffffffff, 5'd0, 5'd0, 1'b0);
    cur_req = "R6";
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, 1'b0);
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, 1'b0);
    // R4: clear has no effect in flop style; R5 drop of write to 3 in memory style
    cur_req = "R5";
    step(1'b1, 5'd3, 32'h0bad0bad, 5'd3, 5'd0, 1'b1);
    step(1'b0, 5'd0, 32'h0, 5'd3, 5'd0, 1'b0);
    step(1'b0, 5'd0, 32'h0, 5'd3, 5'd0, 1'b0);

    // R7: same-cycle read of the written register returns the old word
    cur_req = "R7";
    step(1'b1, 5'd5, 32'h12345678, 5'd5, 5'd5, 1'b0);
    step(1'b0, 5'd0, 32'h0, 5'd5, 5'd5, 1'b0);
    step(1'b0, 5'd0, 32'h0, 5'd5, 5'd5, 1'b0);

    // R8: in the 16-register variant, 20 aliases 4 and 16 aliases 0
    cur_req = "R8";
    step(1'b1, 5'd20, 32'hcafef00d, 5'd4, 5'd20, 1'b0);
    step(1'b1, 5'd16, 32'h77777777, 5'd4, 5'd20, 1'b0);
    step(1'b0, 5'd0, 32'h0, 5'd16, 5'd0, 1'b0);
    step(1'b0, 5'd0, 32'h0, 5'd4, 5'd20, 1'b0);

    // R3: mid-run reset wipes the flop banks, memory array keeps its data
    cur_req = "R3";
    step(1'b0, 5'd0, 32'h0, 5'd9, 5'd10, 1'b0);
    rst_ni = 1'b0;
    repeat (2) step(1'b0, 5'd0, 32'h0, 5'd9, 5'd10, 1'b0);
    rst_ni = 1'b1;
    read_all();

    finish_run();
  end
endmodule